// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block produces the serial clock of an I2C master from one peripheral clock and tells the byte engine when SDA may be driven, when it should be sampled, and when a START or STOP edge may be placed. The low and high phases of SCL are set independently. Each phase is a whole number of 8-cycle units, and the number of units comes from one of two 16-bit fields packed into a single divider word. A hold count, also in 8-cycle units, places the SDA drive point inside the low phase and the START/STOP point inside the high phase. An extra-setup flag adds one more unit before a START, which is the normal setting at standard-mode rates.

The controller is a four-state machine. ST_IDLE is entered while the engine is disabled and leaves SCL released. ST_LOW drives SCL low. ST_HIGH releases SCL. ST_PARK holds SCL released after a STOP. The transitions are:
- IDLE→LOW when enabled.
- LOW→HIGH at the end of the low count.
- HIGH→LOW at the end of the high count.
- HIGH→PARK on the STOP strobe.
- Any state→IDLE when the enable drops.

During ST_HIGH the count advances only in cycles where the sensed SCL reads high. This lets a slave stretch the clock.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is asserted or `enable_i` is low, `scl_low_o` and all four strobes are 0. The first cycle with `scl_low_o` = 1 is the cycle after the first clock edge that samples `enable_i` high.
- R2: `div_word_i[31:16]` is the high-phase field H and `div_word_i[15:0]` is the low-phase field L.
- R3: A low phase lasts exactly 8*(L+1) cycles, so L = 0 gives 8 cycles.
- R4: Without stretching, a high phase lasts exactly 8*(H+1) cycles, so one SCL period is 8*((L+1)+(H+1)) cycles.
- R5: Each cycle of ST_HIGH in which `scl_in_i` is 0 freezes the high count and lengthens the high phase by one cycle. No strobe fires in such a cycle.
- R6: `sda_drive_stb_o` pulses once per low phase, at low cycle index 8*hold (index 0 is the first low cycle). It does not pulse when hold > L.
- R7: `sda_sample_stb_o` pulses once per high phase, when 4*(H+1) counted high cycles have elapsed.
- R8: With `start_req_i` = 1, `start_stb_o` pulses in the high phase at counted index 8*(hold + `start_extra_i`).
- R9: With `stop_req_i` = 1 and `start_req_i` = 0, `stop_stb_o` pulses at that same index. The block then parks: SCL stays released and no strobe fires until `enable_i` goes low.
- R10: Lowering `enable_i` mid-phase releases SCL in the next cycle. Re-enabling starts a full-length low phase.
- R11: When both requests are high, only `start_stb_o` fires; a START has priority over a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Runs the generator; low returns it to idle |
| div_word_i | input | 32 | High-phase field in [31:16], low-phase field in [15:0] |
| hold_i | input | 4 | SDA hold/setup delay in 8-cycle units |
| start_extra_i | input | 1 | Adds one unit of setup before a START |
| start_req_i | input | 1 | Byte engine asks for a START in this high phase |
| stop_req_i | input | 1 | Byte engine asks for a STOP in this high phase |
| scl_in_i | input | 1 | Sensed (synchronised) SCL line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_stb_o | output | 1 | SDA may change in this cycle |
| sda_sample_stb_o | output | 1 | Sample SDA in this cycle |
| start_stb_o | output | 1 | Pull SDA low now for a START |
| stop_stb_o | output | 1 | Release SDA now for a STOP |

## Verification
`scl_low_o` is decoded from the state register, so it changes one clock edge after the enable or the phase end that causes it. The strobes are decoded from the state and the count registers together with the live `scl_in_i`, so each strobe is valid in the same cycle as its count value. The bench samples every output on the falling edge. It numbers each phase's cycles from the first falling edge on which that phase is visible and compares the strobe indices and phase lengths with formulas in L, H and hold. For stretching, the bench pulls the sensed line low between a falling and a rising edge. This freezes exactly one rising edge per stretched cycle, so the expected length and midpoint move by exactly the stretch count.

// File: rtl/scl_tmg_pkg.sv
package scl_tmg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_PARK = 2'd3
    } scl_state_e;
endpackage

// File: rtl/scl_unit_counter.sv
module scl_unit_counter #(
    parameter int FIELD_W = 16,
    parameter int PRE_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               adv_i,
    output logic [PRE_W-1:0]   pre_o,
    output logic [FIELD_W-1:0] unit_o,
    output logic               unit_end_o
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    logic [PRE_W-1:0]   pre_q;
    logic [FIELD_W-1:0] unit_q;

    // prescale counter carries into the unit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (clear_i) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (adv_i) begin
            pre_q <= pre_q + 1'b1;
            if (pre_q == PRE_LAST)
                unit_q <= unit_q + 1'b1;
        end
    end

    assign unit_end_o = adv_i && (pre_q == PRE_LAST);
    assign pre_o      = pre_q;
    assign unit_o     = unit_q;

    // R3
    carry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i && pre_q == PRE_LAST) |=> (pre_q == '0 && unit_q == $past(unit_q) + 1'b1));
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
    import scl_tmg_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int PRE_W   = 3,
    parameter int HOLD_W  = 4
) (
    input  scl_state_e                 state_i,
    input  logic                       en_i,
    input  logic                       scl_in_i,
    input  logic [FIELD_W+PRE_W-1:0]   elapsed_i,
    input  logic [FIELD_W-1:0]         high_f_i,
    input  logic [HOLD_W-1:0]          hold_i,
    input  logic                       extra_i,
    input  logic                       start_req_i,
    input  logic                       stop_req_i,
    output logic                       drive_stb_o,
    output logic                       sample_stb_o,
    output logic                       start_stb_o,
    output logic                       stop_stb_o
);
    localparam int EW = FIELD_W + PRE_W;

    logic [EW-1:0]     hold_pt;
    logic [EW-1:0]     mid_pt;
    logic [EW-1:0]     setup_pt;
    logic [HOLD_W:0]   setup_units;
    logic [FIELD_W:0]  high_units;
    logic              high_live;
    logic              cond_pt;

    always_comb begin
        setup_units = {1'b0, hold_i} + {{HOLD_W{1'b0}}, extra_i};
        high_units  = {1'b0, high_f_i} + 1'b1;
        hold_pt     = EW'(hold_i) << PRE_W;
        setup_pt    = EW'(setup_units) << PRE_W;
        mid_pt      = EW'(high_units) << (PRE_W - 1);
        high_live   = en_i && (state_i == ST_HIGH) && scl_in_i;
        cond_pt     = high_live && (elapsed_i == setup_pt);

        drive_stb_o  = en_i && (state_i == ST_LOW) && (elapsed_i == hold_pt);
        sample_stb_o = high_live && (elapsed_i == mid_pt);
        start_stb_o  = cond_pt && start_req_i;
        stop_stb_o   = cond_pt && stop_req_i && !start_req_i;
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_tmg_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int PRE_W   = 3,
    parameter int HOLD_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic [2*FIELD_W-1:0] div_word_i,
    input  logic [HOLD_W-1:0]    hold_i,
    input  logic                 start_extra_i,
    input  logic                 start_req_i,
    input  logic                 stop_req_i,
    input  logic                 scl_in_i,
    output logic                 scl_low_o,
    output logic                 sda_drive_stb_o,
    output logic                 sda_sample_stb_o,
    output logic                 start_stb_o,
    output logic                 stop_stb_o
);
    localparam int EW = FIELD_W + PRE_W;

    scl_state_e          state_q, state_d;
    logic [FIELD_W-1:0]  low_f, high_f;
    logic [PRE_W-1:0]    pre_cnt;
    logic [FIELD_W-1:0]  unit_cnt;
    logic                unit_end;
    logic                cnt_clear, cnt_adv;
    logic [EW-1:0]       elapsed;
    logic                low_done, high_done;
    logic                stop_hit;

    assign low_f  = div_word_i[FIELD_W-1:0];
    assign high_f = div_word_i[2*FIELD_W-1:FIELD_W];

    scl_unit_counter #(.FIELD_W(FIELD_W), .PRE_W(PRE_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (cnt_clear),
        .adv_i      (cnt_adv),
        .pre_o      (pre_cnt),
        .unit_o     (unit_cnt),
        .unit_end_o (unit_end)
    );

    assign elapsed = {unit_cnt, pre_cnt};

    scl_strobe_gen #(.FIELD_W(FIELD_W), .PRE_W(PRE_W), .HOLD_W(HOLD_W)) stb_i (
        .state_i      (state_q),
        .en_i         (enable_i),
        .scl_in_i     (scl_in_i),
        .elapsed_i    (elapsed),
        .high_f_i     (high_f),
        .hold_i       (hold_i),
        .extra_i      (start_extra_i),
        .start_req_i  (start_req_i),
        .stop_req_i   (stop_req_i),
        .drive_stb_o  (sda_drive_stb_o),
        .sample_stb_o (sda_sample_stb_o),
        .start_stb_o  (start_stb_o),
        .stop_stb_o   (stop_hit)
    );

    assign stop_stb_o = stop_hit;
    assign cnt_adv    = (state_q == ST_LOW) || (state_q == ST_HIGH && scl_in_i);
    assign low_done   = (state_q == ST_LOW)  && unit_end && (unit_cnt == low_f);
    assign high_done  = (state_q == ST_HIGH) && unit_end && (unit_cnt == high_f);
    assign cnt_clear  = (state_d != state_q) || (state_q == ST_IDLE) || (state_q == ST_PARK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable_i) state_d = ST_LOW;
            ST_LOW: begin
                if (!enable_i)     state_d = ST_IDLE;
                else if (low_done) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!enable_i)      state_d = ST_IDLE;
                else if (stop_hit)  state_d = ST_PARK;
                else if (high_done) state_d = ST_LOW;
            end
            ST_PARK: if (!enable_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        scl_low_o = (state_q == ST_LOW);
    end

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == ST_IDLE && !scl_low_o));

    // R5
    stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && state_q == ST_HIGH && !scl_in_i) |=> (state_q == ST_HIGH && $stable(elapsed)));

    // R3
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && $past(state_q) == ST_LOW) |->
            ($past(elapsed) == {$past(low_f), {PRE_W{1'b1}}}));

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && $past(state_q) == ST_HIGH) |->
            ($past(elapsed) == {$past(high_f), {PRE_W{1'b1}}}));

    // R9
    park_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb_o && enable_i) |=> (state_q == ST_PARK && !scl_low_o));
endmodule

// File: tb/scl_phase_gen_tb_top.sv
module scl_phase_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] div_word = '0;
    logic [3:0]  hold = '0;
    logic        start_extra = 1'b0, start_req = 1'b0, stop_req = 1'b0;
    logic        stretch = 1'b0;
    logic        scl_low, drv, smp, sta, sto;
    wire         scl_in = ~scl_low & ~stretch;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    scl_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .div_word_i(div_word),
        .hold_i(hold), .start_extra_i(start_extra), .start_req_i(start_req),
        .stop_req_i(stop_req), .scl_in_i(scl_in), .scl_low_o(scl_low),
        .sda_drive_stb_o(drv), .sda_sample_stb_o(smp),
        .start_stb_o(sta), .stop_stb_o(sto)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_gap();
        enable = 1'b0; start_req = 1'b0; stop_req = 1'b0; stretch = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic measure_low(output int len, output int drv_idx, output int drv_cnt);
        int guard = 0;
        drv_idx = -1; drv_cnt = 0;
        while (!scl_low && guard < 1000) begin @(negedge clk); guard++; end
        len = 0;
        while (scl_low && len < 100000) begin
            if (drv) begin drv_cnt++; if (drv_idx < 0) drv_idx = len; end
            len++;
            @(negedge clk);
        end
    endtask

    task automatic measure_high(input int st_at, input int st_len, input int limit,
                                output int len, output int smp_idx, output int cond_idx,
                                output int n_start, output int n_stop);
        smp_idx = -1; cond_idx = -1; n_start = 0; n_stop = 0; len = 0;
        while (!scl_low && len < limit) begin
            if (smp && smp_idx < 0) smp_idx = len;
            if (sta) begin n_start++; if (cond_idx < 0) cond_idx = len; end
            if (sto) begin n_stop++;  if (cond_idx < 0) cond_idx = len; end
            if (st_len > 0 && len == st_at) stretch = 1'b1;
            if (st_len > 0 && len == st_at + st_len) stretch = 1'b0;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(scl_low == 1'b0, "R1 scl in reset", scl_low, 0);
        check({drv, smp, sta, sto} == 4'b0, "R1 strobes in reset", {drv, smp, sta, sto}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(scl_low == 1'b0, "R1 scl while disabled", scl_low, 0);
        enable = 1'b1;
        @(negedge clk);
        check(scl_low == 1'b1, "R1 low one edge after enable", scl_low, 1);
        idle_gap();
    endtask

    task automatic t_basic();
        int len, di, dc, hl, si, ci, ns, np;
        div_word = {16'd2, 16'd1}; hold = 4'd1;
        enable = 1'b1;
        measure_low(len, di, dc);
        check(len == 16, "R2 R3 low length", len, 16);
        check(di == 8, "R6 drive index", di, 8);
        check(dc == 1, "R6 one drive per low", dc, 1);
        measure_high(0, 0, 1000, hl, si, ci, ns, np);
        check(hl == 24, "R2 R4 high length", hl, 24);
        check(si == 12, "R7 sample index", si, 12);
        measure_low(len, di, dc);
        check(len == 16, "R3 second low length", len, 16);
        idle_gap();
    endtask

    task automatic t_zero();
        int len, di, dc, hl, si, ci, ns, np;
        div_word = 32'd0; hold = 4'd0;
        enable = 1'b1;
        measure_low(len, di, dc);
        check(len == 8, "R3 zero field low", len, 8);
        check(di == 0, "R6 drive at zero hold", di, 0);
        measure_high(0, 0, 1000, hl, si, ci, ns, np);
        check(hl == 8, "R4 zero field high", hl, 8);
        check(si == 4, "R7 sample at 4", si, 4);
        idle_gap();
        hold = 4'd2;
        enable = 1'b1;
        measure_low(len, di, dc);
        check(dc == 0, "R6 no drive when hold exceeds low", dc, 0);
        idle_gap();
    endtask

    task automatic t_stretch();
        int len, di, dc, hl, si, ci, ns, np;
        div_word = {16'd3, 16'd1}; hold = 4'd1;
        enable = 1'b1;
        measure_low(len, di, dc);
        measure_high(2, 5, 1000, hl, si, ci, ns, np);
        check(hl == 37, "R5 stretched high length", hl, 37);
        check(si == 21, "R5 sample shifted by stretch", si, 21);
        idle_gap();
    endtask

    task automatic t_start();
        int len, di, dc, hl, si, ci, ns, np;
        div_word = {16'd3, 16'd1}; hold = 4'd1; start_extra = 1'b1;
        start_req = 1'b1; stop_req = 1'b1;
        enable = 1'b1;
        measure_low(len, di, dc);
        measure_high(0, 0, 1000, hl, si, ci, ns, np);
        check(ci == 16, "R8 start with extra setup", ci, 16);
        check(ns == 1, "R8 one start strobe", ns, 1);
        check(np == 0, "R11 start beats stop", np, 0);
        check(hl == 32, "R11 no park on start", hl, 32);
        measure_low(len, di, dc);
        start_extra = 1'b0;
        measure_high(0, 0, 1000, hl, si, ci, ns, np);
        check(ci == 8, "R8 start without extra", ci, 8);
        idle_gap();
    endtask

    task automatic t_stop();
        int len, di, dc, hl, si, ci, ns, np;
        div_word = {16'd3, 16'd1}; hold = 4'd1; start_extra = 1'b0;
        stop_req = 1'b1;
        enable = 1'b1;
        measure_low(len, di, dc);
        measure_high(0, 0, 60, hl, si, ci, ns, np);
        check(ci == 8 && np == 1, "R9 stop index", ci, 8);
        check(hl == 60, "R9 scl stays released", hl, 60);
        check(si == -1, "R9 no strobe after park", si, -1);
        enable = 1'b0; stop_req = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        measure_low(len, di, dc);
        check(len == 16, "R10 restart after park", len, 16);
        idle_gap();
    endtask

    task automatic t_disable();
        int len, di, dc, guard;
        div_word = {16'd2, 16'd1}; hold = 4'd1;
        enable = 1'b1;
        guard = 0;
        while (!scl_low && guard < 100) begin @(negedge clk); guard++; end
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_low == 1'b0, "R10 release after disable", scl_low, 0);
        @(negedge clk);
        enable = 1'b1;
        measure_low(len, di, dc);
        check(len == 16, "R10 full low after re-enable", len, 16);
        idle_gap();
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_zero();
        t_stretch();
        t_start();
        t_stop();
        t_disable();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule